// File: doc/BRIEF.md
# Flash Page Write Sequencer

This block is the host-side engine that rewrites one whole page of a byte-wide parallel flash device. The device uses active-low chip-select, read-enable and write-strobe lines. A caller gives a page number and a flag that requests the three-write unlock prefix, then supplies the page contents as a valid/ready byte stream. The sequencer turns each byte into one write strobe. Every strobe has a fixed low width and at least a minimum high width. While the strobe is high the stream is held off, so no byte is taken before the next strobe can legally begin.

When the last byte of the page has been loaded, the device programs the page on its own. The sequencer then reads the address of the final byte again and again. It waits until the most significant data bit equals the bit that was written, and then reports success. Two conditions end the operation with an error instead. The first is a data stream that runs dry for longer than the device's inter-byte window. The second is polling that outlasts a configurable limit.

Top module: `flash_page_writer`

## Requirements
- R1: While reset is held and after it is released, the three device control lines are high (inactive). `busy`, `byteReady`, `doneOk`, `doneErr` and `flashDoe` are all low.
- R2: Every write strobe (`flashWeN` low) lasts exactly `LOW_CYC` clock cycles.
- R3: Within one operation, `flashWeN` stays high for at least `HIGH_CYC` cycles between two strobes.
- R4: `flashOeN` is high in every cycle in which `flashWeN` is low.
- R5: `flashAddr` and `flashDout` do not change while a strobe is low.
- R6: When `unlockIn` is 1 at start, the first three writes are data 0xAA at address 0x5555, then data 0x55 at address 0x2AAA, then data 0xA0 at address 0x5555. When `unlockIn` is 0, no such writes are issued and only the page writes appear.
- R7: A successful operation writes exactly `PAGE_BYTES` bytes. Write i (i counted from 0) goes to address {page, i}, with the page number in the upper bits and i in the low log2(`PAGE_BYTES`) bits. Its data is stream byte i.
- R8: A stream byte is taken only in a cycle where `byteValid` and `byteReady` are both 1. `byteReady` is 1 only while the strobe is high and the minimum high time has been met. Idle gaps in the stream change neither the order nor the values of the writes.
- R9: Suppose at least one write of the operation has been issued and no further byte is offered for `WINDOW_CYC` cycles after the previous strobe rose. Then `doneErr` pulses exactly `WINDOW_CYC` cycles after that rising edge, the block returns to idle, and no further strobe is issued.
- R10: After the last write, the block drives `flashOeN` low at the address of the last write, for `READ_CYC`-cycle reads separated by high gaps. `doneOk` pulses only after a read in which bit 7 equals bit 7 of the last written byte. If the device is already complete, `doneOk` appears `HIGH_CYC + READ_CYC` cycles after the last strobe rose.
- R11: If no read matches, `doneErr` pulses exactly `HIGH_CYC + TIMEOUT_CYC` cycles after the last strobe rose.
- R12: `flashCeN` is low throughout an operation and high while the block is idle. `flashDoe` is never 1 while `flashOeN` is low, and it is always 1 while a strobe is low.
- R13: A `startReq` that arrives while `busy` is 1 has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start one page operation (taken only when idle) |
| sectorIn | input | ADDR_W-log2(PAGE_BYTES) | Page number to write |
| unlockIn | input | 1 | Send the three-write unlock prefix first |
| busy | output | 1 | Operation in progress |
| byteValid | input | 1 | Stream byte available |
| byteReady | output | 1 | Sequencer can take the stream byte this cycle |
| byteData | input | DATA_W | Stream byte |
| doneOk | output | 1 | One-cycle pulse: page programmed |
| doneErr | output | 1 | One-cycle pulse: window expired or polling timed out |
| flashAddr | output | ADDR_W | Device address bus |
| flashDout | output | DATA_W | Data driven toward the device |
| flashDoe | output | 1 | Enable for driving `flashDout` onto the shared data bus |
| flashDin | input | DATA_W | Data read from the device |
| flashCeN | output | 1 | Device chip select, active low |
| flashOeN | output | 1 | Device read enable, active low |
| flashWeN | output | 1 | Device write strobe, active low |

## Verification
The hardest case to reach from the ports is the expired inter-byte window. It occurs only when the stream goes silent in the middle of a page after at least one write has been made. The bench sends 20 bytes and then withholds `byteValid`. It then checks the error pulse against the 20th rising strobe and watches that no strobe follows. Polling paths need a device that stays busy for a chosen time. For this, a behavioural flash model in the bench returns an inverted bit 7 until a per-test delay has passed since the last strobe. An endless delay exercises the timeout.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_LOW,
    ST_READ,
    ST_REST
  } fpwState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capSector;  // latch page number and prefix request
    logic capCmd;     // load next unlock write into the output registers
    logic capByte;    // load next stream byte into the output registers
    logic cntClr;     // restart the phase counter
    logic tmoClr;     // restart the polling timeout counter
    logic tmoRun;     // advance the polling timeout counter
  } fpwStrobe_t;

  // Unlock prefix, indexed by the number of prefix writes still to go
  function automatic logic [15:0] unlockAddr(input logic [1:0] left);
    unlockAddr = (left == 2'd2) ? 16'h2AAA : 16'h5555;
  endfunction

  function automatic logic [7:0] unlockData(input logic [1:0] left);
    case (left)
      2'd3:    unlockData = 8'hAA;
      2'd2:    unlockData = 8'h55;
      default: unlockData = 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/fpw_datapath.sv
module fpw_datapath
  import fpw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int CNT_W       = 8,
  parameter int TMO_W       = 8,
  parameter int TIMEOUT_CYC = 100
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  fpwStrobe_t                           stb,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] sectorIn,
  input  logic                                 unlockIn,
  input  logic [DATA_W-1:0]                    byteData,
  input  logic [DATA_W-1:0]                    flashDin,
  output logic [ADDR_W-1:0]                    addrQ,
  output logic [DATA_W-1:0]                    dataQ,
  output logic [CNT_W-1:0]                     phaseCnt,
  output logic                                 cmdPending,
  output logic                                 bytePending,
  output logic                                 primed,
  output logic                                 pollMatch,
  output logic                                 tmoHit
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int SEC_W = ADDR_W - OFF_W;
  localparam logic [OFF_W:0]   PAGE_N  = (OFF_W + 1)'(PAGE_BYTES);
  localparam logic [TMO_W-1:0] TMO_END = TMO_W'(TIMEOUT_CYC - 1);

  logic [SEC_W-1:0] sectorQ;
  logic [1:0]       cmdLeft;
  logic [OFF_W:0]   byteCnt;
  logic [TMO_W-1:0] tmoCnt;

  // Page, prefix progress and bus output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectorQ <= '0;
      cmdLeft <= '0;
      byteCnt <= '0;
      primed  <= 1'b0;
      addrQ   <= '0;
      dataQ   <= '0;
    end else begin
      if (stb.capSector) begin
        sectorQ <= sectorIn;
        cmdLeft <= unlockIn ? 2'd3 : 2'd0;
        byteCnt <= '0;
        primed  <= 1'b0;
      end
      if (stb.capCmd) begin
        addrQ   <= ADDR_W'(unlockAddr(cmdLeft));
        dataQ   <= DATA_W'(unlockData(cmdLeft));
        cmdLeft <= cmdLeft - 2'd1;
        primed  <= 1'b1;
      end
      if (stb.capByte) begin
        addrQ   <= {sectorQ, byteCnt[OFF_W-1:0]};
        dataQ   <= byteData;
        byteCnt <= byteCnt + 1'b1;
        primed  <= 1'b1;
      end
    end
  end

  // Saturating phase counter and polling timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      tmoCnt   <= '0;
    end else begin
      if (stb.cntClr)          phaseCnt <= '0;
      else if (~&phaseCnt)     phaseCnt <= phaseCnt + 1'b1;
      if (stb.tmoClr)          tmoCnt <= '0;
      else if (stb.tmoRun && ~&tmoCnt) tmoCnt <= tmoCnt + 1'b1;
    end
  end

  assign cmdPending  = (cmdLeft != 2'd0);
  assign bytePending = (byteCnt < PAGE_N);
  assign pollMatch   = (flashDin[DATA_W-1] == dataQ[DATA_W-1]);
  assign tmoHit      = (tmoCnt >= TMO_END);

endmodule

// File: rtl/fpw_control.sv
module fpw_control
  import fpw_pkg::*;
#(
  parameter int LOW_CYC    = 5,
  parameter int HIGH_CYC   = 6,
  parameter int READ_CYC   = 8,
  parameter int WINDOW_CYC = 6000,
  parameter int CNT_W      = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             byteValid,
  input  logic [CNT_W-1:0] phaseCnt,
  input  logic             cmdPending,
  input  logic             bytePending,
  input  logic             primed,
  input  logic             pollMatch,
  input  logic             tmoHit,
  output fpwStrobe_t       stb,
  output logic             byteReady,
  output logic             ceN,
  output logic             oeN,
  output logic             weN,
  output logic             doe,
  output logic             busy,
  output logic             doneOk,
  output logic             doneErr
);

  localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_END = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] READ_END = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_END  = CNT_W'(WINDOW_CYC - 1);

  fpwState_e st, nxt;
  logic finOk, finErr;
  logic highMet, readEnd;

  assign highMet = (phaseCnt >= HIGH_END);
  assign readEnd = (phaseCnt >= READ_END);

  always_comb begin
    nxt       = st;
    stb       = '0;
    byteReady = 1'b0;
    finOk     = 1'b0;
    finErr    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (startReq) begin
          stb.capSector = 1'b1;
          stb.cntClr    = 1'b1;
          nxt           = ST_GAP;
        end
      end
      ST_GAP: begin
        if (highMet) begin
          if (cmdPending) begin
            stb.capCmd = 1'b1;
            stb.cntClr = 1'b1;
            nxt        = ST_LOW;
          end else if (bytePending) begin
            byteReady = 1'b1;
            if (byteValid) begin
              stb.capByte = 1'b1;
              stb.cntClr  = 1'b1;
              nxt         = ST_LOW;
            end else if (primed && phaseCnt >= WIN_END) begin
              finErr = 1'b1;
              nxt    = ST_IDLE;
            end
          end else begin
            stb.cntClr = 1'b1;
            stb.tmoClr = 1'b1;
            nxt        = ST_READ;
          end
        end
      end
      ST_LOW: begin
        if (phaseCnt >= LOW_END) begin
          stb.cntClr = 1'b1;
          nxt        = ST_GAP;
        end
      end
      ST_READ: begin
        stb.tmoRun = 1'b1;
        if (readEnd && pollMatch) begin
          finOk = 1'b1;
          nxt   = ST_IDLE;
        end else if (tmoHit) begin
          finErr = 1'b1;
          nxt    = ST_IDLE;
        end else if (readEnd) begin
          stb.cntClr = 1'b1;
          nxt        = ST_REST;
        end
      end
      ST_REST: begin
        stb.tmoRun = 1'b1;
        if (tmoHit) begin
          finErr = 1'b1;
          nxt    = ST_IDLE;
        end else if (highMet) begin
          stb.cntClr = 1'b1;
          nxt        = ST_READ;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      doneOk  <= 1'b0;
      doneErr <= 1'b0;
    end else begin
      st      <= nxt;
      doneOk  <= finOk;
      doneErr <= finErr;
    end
  end

  assign busy = (st != ST_IDLE);
  assign ceN  = (st == ST_IDLE);
  assign weN  = (st != ST_LOW);
  assign oeN  = (st != ST_READ);
  assign doe  = (st == ST_GAP) || (st == ST_LOW);

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import fpw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int LOW_CYC     = 5,
  parameter int HIGH_CYC    = 6,
  parameter int READ_CYC    = 8,
  parameter int WINDOW_CYC  = 6000,
  parameter int TIMEOUT_CYC = 600000
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 startReq,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] sectorIn,
  input  logic                                 unlockIn,
  output logic                                 busy,
  input  logic                                 byteValid,
  output logic                                 byteReady,
  input  logic [DATA_W-1:0]                    byteData,
  output logic                                 doneOk,
  output logic                                 doneErr,
  output logic [ADDR_W-1:0]                    flashAddr,
  output logic [DATA_W-1:0]                    flashDout,
  output logic                                 flashDoe,
  input  logic [DATA_W-1:0]                    flashDin,
  output logic                                 flashCeN,
  output logic                                 flashOeN,
  output logic                                 flashWeN
);

  localparam int MAX_A   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_B   = (READ_CYC > WINDOW_CYC) ? READ_CYC : WINDOW_CYC;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int TMO_W   = $clog2(TIMEOUT_CYC + 1);

  fpwStrobe_t       stb;
  logic [CNT_W-1:0] phaseCnt;
  logic cmdPending, bytePending, primed, pollMatch, tmoHit;

  fpw_control #(
    .LOW_CYC   (LOW_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .READ_CYC  (READ_CYC),
    .WINDOW_CYC(WINDOW_CYC),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .byteValid  (byteValid),
    .phaseCnt   (phaseCnt),
    .cmdPending (cmdPending),
    .bytePending(bytePending),
    .primed     (primed),
    .pollMatch  (pollMatch),
    .tmoHit     (tmoHit),
    .stb        (stb),
    .byteReady  (byteReady),
    .ceN        (flashCeN),
    .oeN        (flashOeN),
    .weN        (flashWeN),
    .doe        (flashDoe),
    .busy       (busy),
    .doneOk     (doneOk),
    .doneErr    (doneErr)
  );

  fpw_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES),
    .CNT_W      (CNT_W),
    .TMO_W      (TMO_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .sectorIn   (sectorIn),
    .unlockIn   (unlockIn),
    .byteData   (byteData),
    .flashDin   (flashDin),
    .addrQ      (flashAddr),
    .dataQ      (flashDout),
    .phaseCnt   (phaseCnt),
    .cmdPending (cmdPending),
    .bytePending(bytePending),
    .primed     (primed),
    .pollMatch  (pollMatch),
    .tmoHit     (tmoHit)
  );

endmodule

// File: rtl/fpw_checker.sv
module fpw_checker #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int LOW_CYC = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              flashWeN,
  input logic              flashOeN,
  input logic              flashCeN,
  input logic              flashDoe,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [DATA_W-1:0] flashDout,
  input logic              byteReady,
  input logic              doneOk,
  input logic              doneErr
);

  logic [7:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lowCnt <= '0;
    else if (flashWeN)  lowCnt <= '0;
    else if (~&lowCnt)  lowCnt <= lowCnt + 1'b1;
  end

  // R2: strobe width
  p_low_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> lowCnt == 8'(LOW_CYC));

  // R4: read enable off during a strobe
  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> flashOeN);

  // R5: bus stable across the strobe
  p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN && $past(!flashWeN)) |-> ($stable(flashAddr) && $stable(flashDout)));

  // R8: stream taken only with strobe and read enable high
  p_ready_gap_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> (flashWeN && flashOeN));

  // R10: completions are exclusive
  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && doneErr));

  // R12: chip selected and bus driven during a strobe, bus released on reads
  p_ce_with_we_r12: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> (!flashCeN && flashDoe));
  p_no_drive_on_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> !flashDoe);

endmodule

bind flash_page_writer fpw_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LOW_CYC(LOW_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .flashWeN (flashWeN),
  .flashOeN (flashOeN),
  .flashCeN (flashCeN),
  .flashDoe (flashDoe),
  .flashAddr(flashAddr),
  .flashDout(flashDout),
  .byteReady(byteReady),
  .doneOk   (doneOk),
  .doneErr  (doneErr)
);

// File: tb/tb_flash_page_writer.sv
module tb_flash_page_writer;

  localparam int LOW  = 5;
  localparam int HIGH = 6;
  localparam int READ = 8;
  localparam int WIN  = 40;
  localparam int TMO  = 2000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [8:0] sectorIn = '0;
  logic       unlockIn = 1'b0;
  logic       busy, byteReady, doneOk, doneErr;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic [15:0] flashAddr;
  logic [7:0] flashDout, flashDin;
  logic       flashDoe, flashCeN, flashOeN, flashWeN;

  always #10 clk = ~clk;

  flash_page_writer #(
    .LOW_CYC(LOW), .HIGH_CYC(HIGH), .READ_CYC(READ),
    .WINDOW_CYC(WIN), .TIMEOUT_CYC(TMO)
  ) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sectorIn(sectorIn),
    .unlockIn(unlockIn), .busy(busy), .byteValid(byteValid),
    .byteReady(byteReady), .byteData(byteData), .doneOk(doneOk),
    .doneErr(doneErr), .flashAddr(flashAddr), .flashDout(flashDout),
    .flashDoe(flashDoe), .flashDin(flashDin), .flashCeN(flashCeN),
    .flashOeN(flashOeN), .flashWeN(flashWeN)
  );

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;

  // behavioural flash model state
  logic [15:0] ldAddr[$];
  logic [7:0]  ldData[$];
  int          lowRun = 0;
  int          highRun = 1000;
  logic [15:0] fAddr = '0;
  logic [7:0]  fData = '0;
  longint      lastRise = 0;
  longint      busyCyc = 0;
  int          expLoads = 0;
  logic [7:0]  lastByte = '0;
  logic        modelReady = 1'b0;
  bit          allowWrites = 1'b1;

  assign flashDin = modelReady ? lastByte : {~lastByte[7], lastByte[6:0]};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'(s * 7 + i * 29 + 3);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // per-cycle protocol monitor and device model
  always @(negedge clk) begin
    if (rstN) begin
      if (!flashWeN) begin
        lowRun++;
        if (lowRun == 1) begin
          if (highRun < HIGH) chk(0, "R3", highRun, HIGH);
          if (!allowWrites)   chk(0, "R9", 1, 0);
          fAddr = flashAddr;
          fData = flashDout;
        end else if (flashAddr != fAddr || flashDout != fData) begin
          chk(0, "R5", flashAddr, fAddr);
        end
        if (!flashOeN) chk(0, "R4", flashOeN, 1);
        if (flashCeN || !flashDoe) chk(0, "R12", flashCeN, 0);
      end else begin
        if (lowRun > 0) begin
          chk(lowRun == LOW, "R2", lowRun, LOW);
          ldAddr.push_back(fAddr);
          ldData.push_back(fData);
          lastByte = fData;
          lastRise = cyc;
          highRun  = 0;
        end
        lowRun = 0;
        highRun++;
      end
      if (!busy && !flashCeN) chk(0, "R12", flashCeN, 1);
      if (!flashOeN && flashDoe) chk(0, "R12", flashDoe, 0);
      if (!flashOeN && ldAddr.size() > 0 && flashAddr != ldAddr[$])
        chk(0, "R10", flashAddr, ldAddr[$]);
      if (doneOk && !modelReady) chk(0, "R10", 0, 1);
      if (byteReady && !flashWeN) chk(0, "R8", byteReady, 0);
    end
    modelReady = (ldAddr.size() >= expLoads) && ((cyc - lastRise) >= busyCyc);
  end

  task automatic runOp(input int sec, input bit unl, input int gapMod, input int nBytes,
                       input longint bsy, input bit midStart,
                       output int kind, output longint doneCyc);
    expLoads = (unl ? 3 : 0) + 128;
    busyCyc  = bsy;
    ldAddr.delete();
    ldData.delete();
    highRun  = 1000;
    allowWrites = 1'b1;
    kind = 0;
    doneCyc = 0;
    @(negedge clk);
    sectorIn = 9'(sec);
    unlockIn = unl;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    fork
      begin
        for (int i = 0; i < nBytes; i++) begin
          if (gapMod > 0) repeat (i % gapMod) @(negedge clk);
          byteValid = 1'b1;
          byteData  = pat(sec, i);
          while (!byteReady) @(negedge clk);
          @(negedge clk);
          byteValid = 1'b0;
        end
      end
      begin
        if (midStart) begin
          repeat (300) @(negedge clk);
          sectorIn = 9'(sec ^ 9'h0F0);
          unlockIn = 1'b0;
          startReq = 1'b1;
          @(negedge clk);
          startReq = 1'b0;
        end
      end
      begin
        for (int w = 0; w < 20000 && kind == 0; w++) begin
          @(negedge clk);
          if (doneOk) kind = 1;
          else if (doneErr) kind = 2;
        end
        doneCyc = cyc;
      end
    join
  endtask

  task automatic cmpLoads(input int sec, input bit unl, input int n, input string req);
    int base;
    base = unl ? 3 : 0;
    chk(ldAddr.size() == base + n, req, ldAddr.size(), base + n);
    if (unl && ldAddr.size() >= 3) begin
      // R6: prefix order and values
      chk(ldAddr[0] == 16'h5555 && ldData[0] == 8'hAA, "R6", ldData[0], 8'hAA);
      chk(ldAddr[1] == 16'h2AAA && ldData[1] == 8'h55, "R6", ldData[1], 8'h55);
      chk(ldAddr[2] == 16'h5555 && ldData[2] == 8'hA0, "R6", ldData[2], 8'hA0);
    end
    for (int i = 0; i < n; i++) begin
      if (base + i < ldAddr.size()) begin
        chk(ldAddr[base+i] == {9'(sec), 7'(i)}, req, ldAddr[base+i], {9'(sec), 7'(i)});
        chk(ldData[base+i] == pat(sec, i), req, ldData[base+i], pat(sec, i));
      end
    end
  endtask

  initial begin
    int kind;
    longint dc;
    bit secOk;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(flashCeN && flashOeN && flashWeN, "R1", {flashCeN, flashOeN, flashWeN}, 3'b111);
    chk(!busy && !byteReady && !doneOk && !doneErr && !flashDoe, "R1",
        {busy, byteReady, doneOk, doneErr, flashDoe}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(flashCeN && flashOeN && flashWeN && !busy && !flashDoe, "R1",
        {flashCeN, flashOeN, flashWeN, busy, flashDoe}, 5'b11100);

    // R7 / R10: plain page, device already done -> fixed latency
    runOp(5, 1'b0, 0, 128, 0, 1'b0, kind, dc);
    chk(kind == 1, "R10", kind, 1);
    chk(dc - lastRise == HIGH + READ, "R10", dc - lastRise, HIGH + READ);
    chk(ldAddr.size() == 128, "R6", ldAddr.size(), 128);  // R6: no prefix without flag
    cmpLoads(5, 1'b0, 128, "R7");

    // R6 / R8 / R13: prefix, stream gaps, stray start, device busy 300 cycles
    runOp(9'h1FF, 1'b1, 5, 128, 300, 1'b1, kind, dc);
    chk(kind == 1, "R10", kind, 1);
    chk(dc - lastRise >= 300 && dc - lastRise <= 300 + HIGH + 2 * READ + 2, "R10",
        dc - lastRise, 300);
    cmpLoads(9'h1FF, 1'b1, 128, "R8");
    secOk = 1'b1;
    for (int k = 3; k < ldAddr.size(); k++) if (ldAddr[k][15:7] != 9'h1FF) secOk = 1'b0;
    chk(secOk, "R13", secOk, 1);

    // R11: device never completes
    runOp(9'h0A3, 1'b1, 0, 128, 64'd1000000, 1'b0, kind, dc);
    chk(kind == 2, "R11", kind, 2);
    chk(dc - lastRise == HIGH + TMO, "R11", dc - lastRise, HIGH + TMO);
    cmpLoads(9'h0A3, 1'b1, 128, "R7");
    chk(!busy, "R11", busy, 0);

    // R9: stream starves after 20 bytes
    runOp(3, 1'b0, 0, 20, 0, 1'b0, kind, dc);
    chk(kind == 2, "R9", kind, 2);
    chk(dc - lastRise == WIN, "R9", dc - lastRise, WIN);
    chk(ldAddr.size() == 20, "R9", ldAddr.size(), 20);
    allowWrites = 1'b0;
    repeat (60) @(negedge clk);
    chk(!busy && flashCeN, "R9", busy, 0);
    allowWrites = 1'b1;

    // R8: recovery after an error, different gap pattern
    runOp(9'h100, 1'b0, 3, 128, 20, 1'b0, kind, dc);
    chk(kind == 1, "R10", kind, 1);
    cmpLoads(9'h100, 1'b0, 128, "R8");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: all requirements actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule